// File: doc/BRIEF.md
# Programmable Slot-Wheel Thread Scheduler

This block decides which hardware thread may issue into a shared in-order pipeline on each clock. It walks a circular wheel of issue slots, one slot per cycle. Each slot is owned by a thread that software chooses. If the owning thread is ready, the block raises an issue strobe and gives the thread number, which then travels with the instruction so that later stages touch the right per-thread state. If the owner is not ready, or the slot is switched off, the cycle becomes a bubble. The slot is never handed to another thread.

Software programs the wheel through a small write port. One kind of write sets a slot entry, made of an owner thread and an enable bit. The other kind sets the number of active slots. Writes first land in a staging copy. The staged table, count and mode are copied into the live wheel only when the pointer wraps, so a rotation is never mixed between old and new contents. A fixed-interleave mode ignores the table and gives slot k to thread k, with as many slots as there are threads.

Top module: `slot_wheel_sched`

## Requirements
- R1: While fixed-interleave mode is live, the wheel has exactly NUM_THREADS slots and slot k belongs to thread k with its enable set. Each thread therefore gets one issue opportunity every NUM_THREADS cycles.
- R2: When the thread owning the current slot has its `threadReady` bit low, `issueValid` is 0 in that cycle, even if other threads are ready.
- R3: The slot pointer `issueSlot` steps by one each clock and returns to 0 after the last live slot, whatever the readiness of any thread.
- R4: When `issueValid` is 1, `issueTid` equals the owner of the current slot. When `issueValid` is 0, `issueTid` reads 0.
- R5: The live slot count may exceed NUM_THREADS, and one thread may own several slots, issuing in each of them.
- R6: A slot whose enable bit is 0 always yields a bubble.
- R7: Slot writes (`cfgIsCount`=0, using `cfgSlotIdx`, `cfgTid`, `cfgSlotEn`), count writes (`cfgIsCount`=1, using `cfgCount`) and the `fixedMode` level are staged. They become live on the clock edge where the pointer leaves its last slot. A write made on that same edge waits for the following wrap.
- R8: A count write of 0 is stored as 1, and a count above MAX_SLOTS is stored as MAX_SLOTS.
- R9: While `rstN` is low, `issueValid` is 0 and `issueSlot` is 0. Reset leaves every slot disabled, the count at 1 and fixed mode off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgIsCount | input | 1 | 1: write slot count, 0: write slot entry |
| cfgSlotIdx | input | PTR_W | Slot entry being written |
| cfgTid | input | TID_W | Owner thread for the slot entry |
| cfgSlotEn | input | 1 | Enable bit for the slot entry |
| cfgCount | input | CNT_W | Requested live slot count |
| fixedMode | input | 1 | Staged request for fixed-interleave mode |
| threadReady | input | NUM_THREADS | Per-thread ready flags |
| issueValid | output | 1 | A thread issues this cycle |
| issueTid | output | TID_W | Issuing thread, 0 on a bubble |
| issueSlot | output | PTR_W | Current wheel slot |

## Verification
The hardest case to reach is a configuration write that lands exactly on the wrap edge. It must stay staged for one more full rotation. That edge only comes once per rotation, and its position moves whenever the count changes. The stimulus therefore writes slot entries, counts and the mode on many consecutive cycles while the wheel runs at several lengths, including length 1 where every edge is a wrap. A behavioural model that tracks its own staged and live copies is compared with the outputs every cycle, so each write that coincides with a wrap is checked for when it takes effect.

// File: rtl/wheel_sched_pkg.sv
`timescale 1ns/1ps
package wheel_sched_pkg;
  // strobes from the wheel control to the slot table
  typedef struct packed {
    logic commit;    // copy staged table into live table this edge
    logic fixedSel;  // live mode is fixed interleave
  } wheelStb_t;
endpackage

// File: rtl/wheel_ctrl.sv
`timescale 1ns/1ps
module wheel_ctrl
  import wheel_sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int MAX_SLOTS   = 8,
  localparam int PTR_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgIsCount,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             fixedMode,
  output logic [PTR_W-1:0] ptr,
  output wheelStb_t        stb
);
  logic [CNT_W-1:0] stagedCount;
  logic [CNT_W-1:0] liveCount;
  logic             liveFixed;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] clampedCount;
  logic             wrap;

  // last live slot index
  always_comb begin
    if (liveFixed) lastIdx = CNT_W'(NUM_THREADS - 1);
    else           lastIdx = liveCount - CNT_W'(1);
  end

  assign wrap = (CNT_W'(ptr) == lastIdx);

  // legal range of the count register is 1..MAX_SLOTS
  always_comb begin
    if (cfgCount == '0)                     clampedCount = CNT_W'(1);
    else if (cfgCount > CNT_W'(MAX_SLOTS))  clampedCount = CNT_W'(MAX_SLOTS);
    else                                    clampedCount = cfgCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (wrap) begin
      ptr <= '0;
    end else begin
      ptr <= ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedCount <= CNT_W'(1);
    end else if (cfgWrEn && cfgIsCount) begin
      stagedCount <= clampedCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCount <= CNT_W'(1);
      liveFixed <= 1'b0;
    end else if (wrap) begin
      liveCount <= stagedCount;
      liveFixed <= fixedMode;
    end
  end

  always_comb begin
    stb.commit   = wrap;
    stb.fixedSel = liveFixed;
  end
endmodule

// File: rtl/slot_table.sv
`timescale 1ns/1ps
module slot_table
  import wheel_sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int MAX_SLOTS   = 8,
  localparam int PTR_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgIsCount,
  input  logic [PTR_W-1:0]       cfgSlotIdx,
  input  logic [TID_W-1:0]       cfgTid,
  input  logic                   cfgSlotEn,
  input  wheelStb_t              stb,
  input  logic [PTR_W-1:0]       ptr,
  input  logic [NUM_THREADS-1:0] threadReady,
  output logic                   issueValid,
  output logic [TID_W-1:0]       issueTid
);
  logic [MAX_SLOTS-1:0] stagedEn;
  logic [MAX_SLOTS-1:0] liveEn;
  logic [TID_W-1:0]     stagedTid [MAX_SLOTS];
  logic [TID_W-1:0]     liveTid   [MAX_SLOTS];

  logic             selEn;
  logic [TID_W-1:0] selTid;

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = cfgWrEn && !cfgIsCount && (cfgSlotIdx == PTR_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stagedEn[s]  <= 1'b0;
        stagedTid[s] <= '0;
      end else if (hit) begin
        stagedEn[s]  <= cfgSlotEn;
        stagedTid[s] <= cfgTid;
      end
    end

    // live copy takes the pre-edge staged value on a wrap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveEn[s]  <= 1'b0;
        liveTid[s] <= '0;
      end else if (stb.commit) begin
        liveEn[s]  <= stagedEn[s];
        liveTid[s] <= stagedTid[s];
      end
    end
  end

  always_comb begin
    if (stb.fixedSel) begin
      selEn  = 1'b1;
      selTid = ptr[TID_W-1:0];
    end else begin
      selEn  = liveEn[ptr];
      selTid = liveTid[ptr];
    end
  end

  assign issueValid = selEn && threadReady[selTid];
  assign issueTid   = issueValid ? selTid : '0;
endmodule

// File: rtl/slot_wheel_sched.sv
`timescale 1ns/1ps
module slot_wheel_sched
  import wheel_sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int MAX_SLOTS   = 8,
  localparam int PTR_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgIsCount,
  input  logic [PTR_W-1:0]       cfgSlotIdx,
  input  logic [TID_W-1:0]       cfgTid,
  input  logic                   cfgSlotEn,
  input  logic [CNT_W-1:0]       cfgCount,
  input  logic                   fixedMode,
  input  logic [NUM_THREADS-1:0] threadReady,
  output logic                   issueValid,
  output logic [TID_W-1:0]       issueTid,
  output logic [PTR_W-1:0]       issueSlot
);
  wheelStb_t        wheelStb;
  logic [PTR_W-1:0] wheelPtr;

  wheel_ctrl #(.NUM_THREADS(NUM_THREADS), .MAX_SLOTS(MAX_SLOTS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgIsCount(cfgIsCount),
    .cfgCount  (cfgCount),
    .fixedMode (fixedMode),
    .ptr       (wheelPtr),
    .stb       (wheelStb)
  );

  slot_table #(.NUM_THREADS(NUM_THREADS), .MAX_SLOTS(MAX_SLOTS)) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgIsCount (cfgIsCount),
    .cfgSlotIdx (cfgSlotIdx),
    .cfgTid     (cfgTid),
    .cfgSlotEn  (cfgSlotEn),
    .stb        (wheelStb),
    .ptr        (wheelPtr),
    .threadReady(threadReady),
    .issueValid (issueValid),
    .issueTid   (issueTid)
  );

  assign issueSlot = wheelPtr;
endmodule

// File: rtl/wheel_sched_chk.sv
`timescale 1ns/1ps
module wheel_sched_chk #(
  parameter int NUM_THREADS = 4,
  parameter int MAX_SLOTS   = 8,
  localparam int PTR_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_THREADS-1:0] threadReady,
  input logic                   issueValid,
  input logic [TID_W-1:0]       issueTid,
  input logic [PTR_W-1:0]       issueSlot,
  input logic                   fixedSel
);
  AST_QUIET_RESET: assert property (@(posedge clk) !rstN |-> (!issueValid && issueSlot == '0)) // R9
    else $error("issue seen during reset");

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (issueSlot == '0 || issueSlot == $past(issueSlot) + PTR_W'(1))) // R3
    else $error("wheel pointer skipped");

  AST_OWNER_READY: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> threadReady[issueTid]) // R2
    else $error("issue by unready thread");

  AST_BUBBLE_TID: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> issueTid == '0) // R4
    else $error("thread id not cleared on bubble");

  AST_FIXED_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (fixedSel && issueValid) |-> (PTR_W'(issueTid) == issueSlot)) // R1
    else $error("fixed mode owner mismatch");

  AST_FIXED_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (fixedSel && issueSlot == PTR_W'(NUM_THREADS - 1)) |=> issueSlot == '0) // R1
    else $error("fixed mode wheel length wrong");
endmodule

bind slot_wheel_sched wheel_sched_chk #(.NUM_THREADS(NUM_THREADS), .MAX_SLOTS(MAX_SLOTS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .threadReady(threadReady),
  .issueValid (issueValid),
  .issueTid   (issueTid),
  .issueSlot  (issueSlot),
  .fixedSel   (wheelStb.fixedSel)
);

// File: tb/tb_slot_wheel_sched.sv
`timescale 1ns/1ps
module tb_slot_wheel_sched;
  localparam int N  = 4;
  localparam int MS = 8;
  localparam int PW = 3;
  localparam int CW = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic          cfgIsCount = 1'b0;
  logic [PW-1:0] cfgSlotIdx = '0;
  logic [TW-1:0] cfgTid = '0;
  logic          cfgSlotEn = 1'b0;
  logic [CW-1:0] cfgCount = '0;
  logic          fixedMode = 1'b0;
  logic [N-1:0]  threadReady = '0;
  logic          issueValid;
  logic [TW-1:0] issueTid;
  logic [PW-1:0] issueSlot;

  slot_wheel_sched #(.NUM_THREADS(N), .MAX_SLOTS(MS)) dut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference
  int  mPtr, mLiveCnt, mStagedCnt;
  bit  mLiveFix;
  bit  mStagedEn [MS];
  bit  mLiveEn   [MS];
  int  mStagedTid[MS];
  int  mLiveTid  [MS];
  int  vectors = 0, errs = 0;
  bit  finished = 0;
  bit  randReady = 0;
  logic [15:0] lfsr = 16'hACE1;
  string phase = "R9";

  task automatic modelReset();
    mPtr = 0; mLiveCnt = 1; mStagedCnt = 1; mLiveFix = 0;
    for (int i = 0; i < MS; i++) begin
      mStagedEn[i] = 0; mLiveEn[i] = 0; mStagedTid[i] = 0; mLiveTid[i] = 0;
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int last;
      last = mLiveFix ? N - 1 : mLiveCnt - 1;
      if (mPtr == last) begin
        for (int i = 0; i < MS; i++) begin
          mLiveEn[i] = mStagedEn[i]; mLiveTid[i] = mStagedTid[i];
        end
        mLiveCnt = mStagedCnt; mLiveFix = fixedMode; mPtr = 0;
      end else mPtr++;
      if (cfgWrEn) begin
        if (cfgIsCount) begin
          if (cfgCount == 0) mStagedCnt = 1;
          else if (cfgCount > MS) mStagedCnt = MS;
          else mStagedCnt = int'(cfgCount);
        end else begin
          mStagedEn[cfgSlotIdx] = cfgSlotEn;
          mStagedTid[cfgSlotIdx] = int'(cfgTid);
        end
      end
    end
  end

  task automatic compare();
    bit expEn, expValid;
    int expTid;
    if (mLiveFix) begin expEn = 1; expTid = mPtr; end
    else begin expEn = mLiveEn[mPtr]; expTid = mLiveTid[mPtr]; end
    expValid = expEn && threadReady[expTid];
    if (!expValid) expTid = 0;
    vectors++;
    if (issueValid !== expValid || issueTid !== TW'(expTid) || issueSlot !== PW'(mPtr)) begin
      errs++;
      $display("FAIL %s t=%0t valid/tid/slot actual %0b/%0d/%0d expected %0b/%0d/%0d",
               phase, $time, issueValid, issueTid, issueSlot, expValid, expTid, mPtr);
    end
  endtask

  // one clock: compare after the edge, then refresh ready pattern
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    compare();
    cfgWrEn = 1'b0;
    if (randReady) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      threadReady = lfsr[N-1:0];
    end
  endtask

  task automatic wrSlot(int idx, int tid, bit en);
    cfgWrEn = 1; cfgIsCount = 0; cfgSlotIdx = PW'(idx); cfgTid = TW'(tid); cfgSlotEn = en;
    tick();
  endtask

  task automatic wrCount(int cnt);
    cfgWrEn = 1; cfgIsCount = 1; cfgCount = CW'(cnt);
    tick();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    threadReady = '1;
    phase = "R9"; run(3);          // reset state: no issue, slot 0
    rstN = 1'b1;
    phase = "R6"; run(4);          // every slot disabled after reset

    // R5: six slots, thread 1 owns three, slot 4 disabled (R6)
    phase = "R5";
    wrSlot(0, 1, 1); wrSlot(1, 1, 1); wrSlot(2, 0, 1);
    wrSlot(3, 2, 1); wrSlot(4, 3, 0); wrSlot(5, 1, 1);
    wrCount(6);
    run(30);
    phase = "R4"; randReady = 1; run(40);

    phase = "R2"; randReady = 0; threadReady = 4'b1101; run(12);
    threadReady = 4'b0000; phase = "R3"; run(12);
    threadReady = '1; randReady = 1;

    // R7: writes on many consecutive cycles, some hitting the wrap edge
    phase = "R7";
    for (int k = 0; k < 48; k++) begin
      if (k % 5 == 0) wrCount(2 + (k % 7));
      else wrSlot(k % MS, (k * 3) % N, (k % 4) != 1);
    end
    run(20);

    // R8: clamping of the count register
    phase = "R8";
    wrCount(0); run(10);
    wrSlot(0, 2, 1); run(6);
    wrCount(13); run(6);
    for (int s = 0; s < MS; s++) wrSlot(s, s % N, 1);
    run(24);
    wrCount(15); run(20);

    // R1: fixed interleave, then back to the table
    phase = "R1"; fixedMode = 1; randReady = 0; threadReady = '1; run(24);
    randReady = 1; run(24);
    wrCount(3); run(12);
    phase = "R7"; fixedMode = 0; run(20);
    wrCount(1); run(6);
    wrSlot(0, 3, 1); run(4);
    wrSlot(0, 0, 0); run(4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule